// File: doc/BRIEF.md
# Prescaled One-Shot / Reload Down-Counter

This block is the 16-bit down-counter that belongs to one waveform-generator channel. Each pulse of the count clock lowers the count by one. The count clock comes from the peripheral clock through a power-of-two prescaler. A registered mode code selects one of two ways of running.

- **One-shot modes** are used to time a dead-time or pulse window. A start pulse loads the programmed initial value. The counter then runs down once, drops its busy output and emits a single-cycle done pulse.
- **Reload modes** are used when the waveform logic does not need the counter. Here it runs by itself as a periodic timer. At the end of every interval it reloads and sets a sticky interrupt flag.

The initial value is captured only when the count is loaded. Any change to it while the counter runs therefore waits for the next load. An initial value of zero stands for 65536 counts. Writing a different mode code abandons the current count. Codes outside the defined set leave the counter stopped.

Top module: `wave_tmr`

## Requirements
- R1: After reset, busy, done, irq_flag and irq are all low.
- R2: In a one-shot mode (mode 3'b010, 3'b100 or 3'b111), the cycle after a start pulse is sampled, busy goes high. It stays high for exactly N×D cycles, where N is the initial value and D the divide ratio. In the first cycle that busy is low again, done is high for that one cycle only.
- R3: div_sel codes 0 to 6 select D = 2^div_sel (1 to 64). Code 7 also selects 64. The first count-clock tick comes one full divided period after the start.
- R4: An initial value of 16'h0000 counts 65536 ticks.
- R5: A change of init_val while busy does not alter the run in progress. The new value applies from the next start.
- R6: In a reload mode (mode 3'b000 or 3'b001), irq_flag is set once every N×D cycles, and done never pulses.
- R7: irq_flag stays set until irq_clr is high at a clock edge. irq equals irq_flag only while irq_en is high, and is low otherwise.
- R8: When mode differs from the last registered mode, the next cycle shows busy low. The abandoned run produces no done pulse.
- R9: In a prohibited mode (3'b011, 3'b101, 3'b110), a start pulse leaves busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start/restart pulse |
| div_sel | input | 3 | Prescaler select, D = 2^div_sel |
| mode | input | 3 | Operating mode code |
| init_val | input | 16 | Initial count value (0 means 65536) |
| irq_en | input | 1 | Interrupt output enable |
| irq_clr | input | 1 | Write-1 clear strobe for irq_flag |
| busy | output | 1 | Counter is running |
| done | output | 1 | One-cycle pulse at end of a one-shot run |
| irq_flag | output | 1 | Sticky reload-interval flag |
| irq | output | 1 | Gated interrupt request |

## Verification
The bench measures busy width at several divide ratios, including the 65536-count zero encoding.

- **Off-by-one load or tick:** a design that loads one early or ticks on the first prescaler cycle would show a width of N×D±1 or N×(D−1).
- **Live initial value:** a design that tracks init_val while running would shorten the run when init_val changes mid-run.
- **Reload interval:** the bench times the reload period between flag sets. A design that counts the load cycle into each period would be out by one cycle.
- **Mode-change abort:** a design that finishes the old count after a mode change would leave busy high or emit a stray done.
- **Flag handling:** the bench checks that the flag is sticky and that the enable gates irq. A design that clears the flag by itself or ignores the enable is caught.

// File: rtl/wave_tmr.sv
module wave_tmr #(
  parameter int CW    = 16,
  parameter int DSW   = 3,
  parameter int MAXSH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [DSW-1:0] div_sel,
  input  logic [2:0]     mode,
  input  logic [CW-1:0]  init_val,
  input  logic           irq_en,
  input  logic           irq_clr,
  output logic           busy,
  output logic           done,
  output logic           irq_flag,
  output logic           irq
);
  localparam int PW = MAXSH;

  logic [2:0]    mode_q;
  logic [CW:0]   cnt;
  logic [PW-1:0] pre;

  wire [DSW-1:0] sh      = (div_sel > DSW'(MAXSH)) ? DSW'(MAXSH) : div_sel;
  wire [PW:0]    pow     = (PW+1)'(1) << sh;
  wire [PW-1:0]  pre_lim = PW'(pow - 1'b1);
  wire           tick    = busy && (pre == pre_lim);
  wire [CW:0]    init_x  = {init_val == '0, init_val};

  wire oneshot    = (mode_q == 3'b010) || (mode_q == 3'b100) || (mode_q == 3'b111);
  wire reload     = (mode_q == 3'b000) || (mode_q == 3'b001);
  wire mode_chg   = (mode != mode_q);
  wire last_tick  = tick && (cnt == (CW+1)'(1));
  wire reload_hit = !mode_chg && !start && reload && last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'b000;
      cnt    <= '0;
      pre    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (mode_chg) begin
        mode_q <= mode;
        cnt    <= '0;
        pre    <= '0;
        busy   <= 1'b0;
      end else if ((start && (oneshot || reload)) || (reload && !busy)) begin
        cnt  <= init_x;
        pre  <= '0;
        busy <= 1'b1;
      end else if (tick) begin
        pre <= '0;
        if (cnt == (CW+1)'(1)) begin
          if (reload) cnt <= init_x;
          else begin
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (busy) begin
        pre <= pre + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq_flag <= 1'b0;
    else if (reload_hit) irq_flag <= 1'b1;
    else if (irq_clr)    irq_flag <= 1'b0;
  end

  assign irq = irq_flag & irq_en;

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_idle_r2:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  p_cnt_range_r4:  assert property (@(posedge clk) disable iff (!rst_n)
                     (busy && oneshot) |-> (cnt != '0 && cnt <= (CW+1)'(1) << CW));
  p_no_done_r6:    assert property (@(posedge clk) disable iff (!rst_n)
                     (reload && !mode_chg) |=> !done);
  p_clear_r7:      assert property (@(posedge clk) disable iff (!rst_n)
                     (irq_clr && !reload_hit) |=> !irq_flag);
  p_sticky_r7:     assert property (@(posedge clk) disable iff (!rst_n)
                     (irq_flag && !irq_clr) |=> irq_flag);
  p_abort_r8:      assert property (@(posedge clk) disable iff (!rst_n)
                     mode_chg |=> (!busy && !done));
  p_bad_mode_r9:   assert property (@(posedge clk) disable iff (!rst_n)
                     (!oneshot && !reload && !mode_chg) |=> !busy);
endmodule

// File: tb/sim_wave_tmr.sv
module sim_wave_tmr;
  localparam int TCLK = 10;

  logic        clk = 0, rst_n = 0, start = 0, irq_en = 0, irq_clr = 0;
  logic [2:0]  div_sel = 0, mode = 3'b010;
  logic [15:0] init_val = 0;
  logic        busy, done, irq_flag, irq;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  wave_tmr u0 (.clk(clk), .rst_n(rst_n), .start(start), .div_sel(div_sel), .mode(mode),
               .init_val(init_val), .irq_en(irq_en), .irq_clr(irq_clr),
               .busy(busy), .done(done), .irq_flag(irq_flag), .irq(irq));

  always #(TCLK/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic run_len(output int len, output bit d_ok);
    len = 0;
    while (busy && len < 70000) begin len++; @(negedge clk); end
    d_ok = done;
    @(negedge clk);
    d_ok = d_ok && !done;
  endtask

  task automatic t_reset();
    check(!busy && !done && !irq_flag && !irq, "R1", {busy, done, irq_flag, irq}, 0);
  endtask

  task automatic t_oneshot(input logic [2:0] m, input logic [2:0] ds, input int n,
                           input int expv, input string req);
    int len; bit d_ok;
    @(negedge clk) mode = m; div_sel = ds; init_val = 16'(n);
    pulse_start();
    run_len(len, d_ok);
    check(len == expv, req, len, expv);
    check(d_ok, "R2", d_ok, 1);
  endtask

  task automatic t_init_latch();
    int len; bit d_ok;
    @(negedge clk) mode = 3'b010; div_sel = 0; init_val = 10;
    pulse_start();
    repeat (3) @(negedge clk);
    init_val = 3;
    len = 3;
    while (busy && len < 100) begin len++; @(negedge clk); end
    check(len == 10, "R5", len, 10);
    pulse_start();
    run_len(len, d_ok);
    check(len == 3, "R5", len, 3);
  endtask

  task automatic wait_flag(output int p);
    p = 1;
    @(negedge clk);
    while (!irq_flag && p < 1000) begin p++; @(negedge clk); end
  endtask

  task automatic t_reload();
    int p; bit any_done = 0;
    @(negedge clk) mode = 3'b000; div_sel = 1; init_val = 5; irq_en = 0;
    wait_flag(p);
    check(irq_flag, "R6", irq_flag, 1);
    check(!irq, "R7", irq, 0);
    for (int k = 0; k < 2; k++) begin
      irq_clr = 1;
      @(negedge clk) irq_clr = 0;
      if (k == 0) check(!irq_flag, "R7", irq_flag, 0);
      p = 1;
      while (!irq_flag && p < 1000) begin
        if (done) any_done = 1;
        p++; @(negedge clk);
      end
      check(p == 10, "R6", p, 10);
    end
    check(!any_done, "R6", any_done, 0);
    irq_en = 1;
    repeat (25) @(negedge clk);
    check(irq_flag, "R7", irq_flag, 1);
    check(irq, "R7", irq, 1);
    irq_clr = 1;
    @(negedge clk) irq_clr = 0; irq_en = 0;
  endtask

  task automatic t_abort();
    bit seen = 0;
    @(negedge clk) mode = 3'b100; div_sel = 2; init_val = 50;
    pulse_start();
    repeat (5) @(negedge clk);
    mode = 3'b111;
    @(negedge clk);
    check(!busy, "R8", busy, 0);
    for (int k = 0; k < 250; k++) begin
      if (busy || done) seen = 1;
      @(negedge clk);
    end
    check(!seen, "R8", seen, 0);
  endtask

  task automatic t_bad_mode();
    bit seen = 0;
    @(negedge clk) mode = 3'b011; init_val = 4; div_sel = 0;
    @(negedge clk);
    pulse_start();
    for (int k = 0; k < 10; k++) begin
      if (busy) seen = 1;
      @(negedge clk);
    end
    check(!seen, "R9", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    repeat (2) @(negedge clk);
    t_oneshot(3'b010, 3'd0, 7, 7, "R2");
    t_oneshot(3'b100, 3'd2, 5, 20, "R3");
    t_oneshot(3'b111, 3'd6, 3, 192, "R3");
    t_oneshot(3'b010, 3'd7, 2, 128, "R3");
    t_oneshot(3'b010, 3'd0, 0, 65536, "R4");
    t_init_latch();
    t_reload();
    t_abort();
    t_bad_mode();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule